// File: doc/BRIEF.md
# Cycle-Synchronous Redundant I/O Driver

This block is the process-side I/O unit shared by two redundant controller channels. A single-cycle tick marks each boundary between control cycles. On that tick the raw digital inputs are captured into two independent snapshot buffers, one per channel. Each channel reads its own buffer through its own port, and the value stays frozen until the next tick, so both channels compute from the same time-aligned picture of the plant.

During a cycle each channel writes an output byte into its own register. On the next tick the two bytes are voted. If they agree, the byte is latched onto the output port and held there for the whole following cycle. If they differ, the block raises a halt flag that stays set until reset. It forces the output port to a configurable safe pattern and stops all further input sampling and output updates.

Top module: `rio_cycle_driver`

## Requirements
- R1: While `rst_n` is low and right after it is released, `dout` equals `SAFE_PAT` (default 8'h00), `halt` is 0, and both read ports return 0.
- R2: On a clock edge where `cycle_tick` is 1 and `halt` is 0, both snapshot buffers load `din`, and the new value is visible on `a_rdata` and `b_rdata` after that edge.
- R3: Between ticks, the snapshot buffers keep their value whatever `din` does.
- R4: `a_rdata` and `b_rdata` always hold the same value.
- R5: A write strobe (`a_wr` or `b_wr`) updates only that channel's output register. A channel that is not written keeps its last byte across cycles. Both registers reset to `SAFE_PAT`.
- R6: On a tick with `halt` at 0 and the two channel bytes equal, `dout` takes that byte after the tick edge.
- R7: `dout` changes only on a clock edge where `cycle_tick` is 1.
- R8: A write presented in the same clock as a tick belongs to the cycle that is ending, so the written byte takes part in that tick's vote.
- R9: On a tick with `halt` at 0 and the two channel bytes different, `halt` becomes 1 and `dout` becomes `SAFE_PAT` after the tick edge.
- R10: Once set, `halt` stays 1 until reset. While it is set, `dout` stays `SAFE_PAT`, and ticks neither resample `din` nor change `dout`.
- R11: Asserting `rst_n` low clears `halt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_tick | input | 1 | One-clock pulse marking the end of one control cycle and the start of the next |
| din | input | IN_W | Raw digital process inputs |
| a_wr | input | 1 | Channel A output byte write strobe |
| a_wdata | input | OUT_W | Channel A output byte |
| b_wr | input | 1 | Channel B output byte write strobe |
| b_wdata | input | OUT_W | Channel B output byte |
| a_rdata | output | IN_W | Channel A view of the input snapshot |
| b_rdata | output | IN_W | Channel B view of the input snapshot |
| dout | output | OUT_W | Voted output port |
| halt | output | 1 | Sticky disagreement flag; the system is stopped |

## Verification
A channel write and the cycle-end vote can fall in the same clock. In that case the write must reach the vote, not wait for the next cycle. The bench provokes this by pulsing both write strobes together with the tick, by staggering the strobes so that only one lands on the tick, and by making a single-channel write on the tick produce a disagreement. A reference model applies every write before each tick's vote, and a scoreboard compares the resulting `dout`, `halt` and snapshot after each tick.

// File: rtl/rio_pkg.sv
package rio_pkg;
  localparam int unsigned NCH = 2;

  typedef enum logic [1:0] {
    VOTE_NONE  = 2'd0,
    VOTE_AGREE = 2'd1,
    VOTE_SPLIT = 2'd2
  } vote_e;
endpackage

// File: rtl/rio_in_snapshot.sv
module rio_in_snapshot #(
  parameter int unsigned IN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snap_en,
  input  logic [IN_W-1:0] din,
  output logic [IN_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (snap_en) rdata <= din;
  end
endmodule

// File: rtl/rio_out_reg.sv
module rio_out_reg #(
  parameter int unsigned            OUT_W    = 8,
  parameter logic [OUT_W-1:0]       SAFE_PAT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [OUT_W-1:0] wdata,
  output logic [OUT_W-1:0] eff
);
  logic [OUT_W-1:0] held;

  // a write in the current clock is already part of the byte seen by the vote
  function automatic logic [OUT_W-1:0] pending_byte(input logic w,
                                                    input logic [OUT_W-1:0] nv,
                                                    input logic [OUT_W-1:0] cur);
    return w ? nv : cur;
  endfunction

  assign eff = pending_byte(wr, wdata, held);

  always_ff @(posedge clk) begin
    if (!rst_n) held <= SAFE_PAT;
    else        held <= eff;
  end
endmodule

// File: rtl/rio_vote.sv
module rio_vote #(
  parameter int unsigned      OUT_W    = 8,
  parameter logic [OUT_W-1:0] SAFE_PAT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [OUT_W-1:0] byte_a,
  input  logic [OUT_W-1:0] byte_b,
  output logic [OUT_W-1:0] dout,
  output logic             halt,
  output logic             split
);
  import rio_pkg::*;

  vote_e verdict;

  function automatic vote_e judge(input logic go,
                                  input logic [OUT_W-1:0] x,
                                  input logic [OUT_W-1:0] y);
    if (!go)    return VOTE_NONE;
    if (x == y) return VOTE_AGREE;
    return VOTE_SPLIT;
  endfunction

  assign verdict = judge(fire && !halt, byte_a, byte_b);
  assign split   = (verdict == VOTE_SPLIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout <= SAFE_PAT;
      halt <= 1'b0;
    end else begin
      case (verdict)
        VOTE_AGREE: dout <= byte_a;
        VOTE_SPLIT: begin
          dout <= SAFE_PAT;
          halt <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rio_cycle_driver.sv
module rio_cycle_driver #(
  parameter int unsigned      IN_W     = 16,
  parameter int unsigned      OUT_W    = 8,
  parameter logic [OUT_W-1:0] SAFE_PAT = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycle_tick,
  input  logic [IN_W-1:0]  din,
  input  logic             a_wr,
  input  logic [OUT_W-1:0] a_wdata,
  input  logic             b_wr,
  input  logic [OUT_W-1:0] b_wdata,
  output logic [IN_W-1:0]  a_rdata,
  output logic [IN_W-1:0]  b_rdata,
  output logic [OUT_W-1:0] dout,
  output logic             halt
);
  localparam int unsigned NCH = rio_pkg::NCH;

  logic                       snap_en;
  logic                       vote_split;
  logic [NCH-1:0]             wr_v;
  logic [NCH-1:0][OUT_W-1:0]  wdat_v;
  logic [NCH-1:0][OUT_W-1:0]  eff_v;
  logic [NCH-1:0][IN_W-1:0]   snap_v;

  assign snap_en = cycle_tick && !halt;
  assign wr_v    = {b_wr, a_wr};
  assign wdat_v  = {b_wdata, a_wdata};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    rio_in_snapshot #(.IN_W(IN_W)) u_snap (
      .clk    (clk),
      .rst_n  (rst_n),
      .snap_en(snap_en),
      .din    (din),
      .rdata  (snap_v[ch])
    );
    rio_out_reg #(.OUT_W(OUT_W), .SAFE_PAT(SAFE_PAT)) u_oreg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_v[ch]),
      .wdata (wdat_v[ch]),
      .eff   (eff_v[ch])
    );
  end

  assign a_rdata = snap_v[0];
  assign b_rdata = snap_v[1];

  rio_vote #(.OUT_W(OUT_W), .SAFE_PAT(SAFE_PAT)) u_vote (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (cycle_tick),
    .byte_a(eff_v[0]),
    .byte_b(eff_v[1]),
    .dout  (dout),
    .halt  (halt),
    .split (vote_split)
  );
endmodule

// File: rtl/rio_cycle_driver_chk.sv
module rio_cycle_driver_chk #(
  parameter int unsigned      IN_W     = 16,
  parameter int unsigned      OUT_W    = 8,
  parameter logic [OUT_W-1:0] SAFE_PAT = 8'h00
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cycle_tick,
  input logic             snap_en,
  input logic             vote_split,
  input logic             halt,
  input logic [OUT_W-1:0] dout,
  input logic [IN_W-1:0]  a_rdata,
  input logic [IN_W-1:0]  b_rdata
);
  // R9
  split_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vote_split |=> (halt && dout == SAFE_PAT));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);

  // R10
  halt_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> dout == SAFE_PAT);

  // R10
  halt_no_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !snap_en);

  // R7
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_tick |=> $stable(dout));

  // R3
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> ($stable(a_rdata) && $stable(b_rdata)));

  // R4
  chan_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_rdata == b_rdata);
endmodule

bind rio_cycle_driver rio_cycle_driver_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .SAFE_PAT(SAFE_PAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cycle_tick(cycle_tick),
  .snap_en   (snap_en),
  .vote_split(vote_split),
  .halt      (halt),
  .dout      (dout),
  .a_rdata   (a_rdata),
  .b_rdata   (b_rdata)
);

// File: tb/tb_rio_cycle_driver.sv
module tb_rio_cycle_driver;
  localparam int unsigned IN_W = 16;
  localparam int unsigned OUT_W = 8;
  localparam logic [OUT_W-1:0] SAFE = 8'h00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cycle_tick = 1'b0;
  logic [IN_W-1:0] din = '0;
  logic a_wr = 1'b0, b_wr = 1'b0;
  logic [OUT_W-1:0] a_wdata = '0, b_wdata = '0;
  logic [IN_W-1:0] a_rdata, b_rdata;
  logic [OUT_W-1:0] dout;
  logic halt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [OUT_W-1:0] m_a, m_b, m_dout;
  logic m_halt;
  logic [IN_W-1:0] m_buf;

  // scoreboard queues
  logic [OUT_W-1:0] q_dout[$];
  logic             q_halt[$];
  logic [IN_W-1:0]  q_rd[$];
  string            q_tag[$];

  always #4 clk = ~clk;

  rio_cycle_driver dut (
    .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick), .din(din),
    .a_wr(a_wr), .a_wdata(a_wdata), .b_wr(b_wr), .b_wdata(b_wdata),
    .a_rdata(a_rdata), .b_rdata(b_rdata), .dout(dout), .halt(halt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_a = SAFE; m_b = SAFE; m_dout = SAFE; m_halt = 1'b0; m_buf = '0;
  endtask

  // one clock of stimulus; pushes an expected result when it ticks
  task automatic drive(input logic tk, input logic [IN_W-1:0] d,
                       input logic wa, input logic [OUT_W-1:0] da,
                       input logic wb, input logic [OUT_W-1:0] db,
                       input string tag);
    logic [OUT_W-1:0] ea, eb;
    @(negedge clk);
    cycle_tick = tk; din = d; a_wr = wa; a_wdata = da; b_wr = wb; b_wdata = db;
    ea = wa ? da : m_a;
    eb = wb ? db : m_b;
    if (tk && !m_halt) begin
      m_buf = d;
      if (ea == eb) m_dout = ea;
      else begin m_halt = 1'b1; m_dout = SAFE; end
    end
    m_a = ea; m_b = eb;
    if (tk) begin
      q_dout.push_back(m_dout); q_halt.push_back(m_halt);
      q_rd.push_back(m_buf); q_tag.push_back(tag);
    end
  endtask

  task automatic idle(input logic [IN_W-1:0] d);
    drive(1'b0, d, 1'b0, '0, 1'b0, '0, "idle");
  endtask

  task automatic settle();
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cycle_tick = 1'b0; a_wr = 1'b0; b_wr = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: after every ticked edge, pop and compare
  initial begin
    logic t;
    forever begin
      @(posedge clk);
      t = cycle_tick && rst_n;
      @(negedge clk);
      if (t) begin
        if (q_dout.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard unexpected tick actual=1 expected=0");
        end else begin
          string tg;
          tg = q_tag.pop_front();
          chk({tg, " dout"}, 32'(dout), 32'(q_dout.pop_front()));
          chk({tg, " halt"}, 32'(halt), 32'(q_halt.pop_front()));
          chk({tg, " a_rdata"}, 32'(a_rdata), 32'(q_rd[0]));
          chk({"R4 ", tg, " b_rdata"}, 32'(b_rdata), 32'(q_rd.pop_front()));
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    settle();
    // R1: values during reset
    chk("R1 dout in reset", 32'(dout), 32'(SAFE));
    chk("R1 halt in reset", 32'(halt), 32'd0);
    chk("R1 rdata in reset", 32'(a_rdata), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    settle();
    chk("R1 halt after release", 32'(halt), 32'd0);

    // R2 R6: tick with no writes votes the reset bytes
    drive(1'b1, 16'hA5A5, 1'b0, '0, 1'b0, '0, "R2 R6 first tick");
    // R5: both written, no tick
    drive(1'b0, 16'h0F0F, 1'b1, 8'h3C, 1'b1, 8'h3C, "R5 write");
    idle(16'hFFFF);
    settle();
    // R3: snapshot unaffected by din changes
    chk("R3 snapshot frozen", 32'(a_rdata), 32'h0000A5A5);
    // R7: dout not moved by writes without tick
    chk("R7 dout held", 32'(dout), 32'(SAFE));
    drive(1'b1, 16'h1234, 1'b0, '0, 1'b0, '0, "R6 agree 3C");
    // R8: writes in the tick clock join the vote
    drive(1'b1, 16'h4321, 1'b1, 8'h5A, 1'b1, 8'h5A, "R8 same-cycle write");
    // R5: no writes, registers hold
    idle(16'h0001);
    drive(1'b1, 16'h2222, 1'b0, '0, 1'b0, '0, "R5 hold");
    // R8: staggered strobes, B only on the tick
    drive(1'b0, 16'h0, 1'b1, 8'hC3, 1'b0, '0, "R8 stagger a");
    drive(1'b1, 16'h3333, 1'b0, '0, 1'b1, 8'hC3, "R8 stagger b on tick");
    for (int i = 0; i < 6; i++) begin
      drive(1'b0, 16'(i * 16'h1111), 1'b1, 8'(i * 37 + 1), 1'b1, 8'(i * 37 + 1), "R6 loop write");
      idle(16'(i));
      drive(1'b1, 16'(16'hBEEF ^ i), 1'b0, '0, 1'b0, '0, "R6 loop tick");
    end
    // R9 R5: only A written on the tick -> disagreement
    drive(1'b1, 16'h7777, 1'b1, 8'h77, 1'b0, '0, "R9 split");
    idle(16'h8888);
    settle();
    chk("R9 halt set", 32'(halt), 32'd1);
    chk("R9 dout safe", 32'(dout), 32'(SAFE));
    // R10: sticky, no sampling, no update
    drive(1'b1, 16'h9999, 1'b1, 8'h11, 1'b1, 8'h11, "R10 halted tick");
    drive(1'b1, 16'hAAAA, 1'b0, '0, 1'b0, '0, "R10 halted tick 2");
    idle(16'h0);
    settle();
    chk("R10 snapshot kept", 32'(a_rdata), 32'h00007777);
    chk("R10 halt kept", 32'(halt), 32'd1);
    // R11: reset clears
    do_reset();
    settle();
    chk("R11 halt cleared", 32'(halt), 32'd0);
    chk("R11 dout safe", 32'(dout), 32'(SAFE));
    chk("R11 snapshot cleared", 32'(b_rdata), 32'd0);
    drive(1'b0, 16'h0, 1'b1, 8'h09, 1'b0, '0, "R5 a only");
    drive(1'b1, 16'h5555, 1'b0, '0, 1'b1, 8'h09, "R6 after reset");
    idle(16'h0);
    idle(16'h0);
    settle();
    chk("R6 final dout", 32'(dout), 32'h09);
    chk("scoreboard drained", 32'(q_dout.size()), 32'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule